// File: doc/BRIEF.md
# Slotted Host Message Queue

This block is a bank of message slots through which a host and an embedded processor exchange short messages. Incoming slots carry traffic from the host to the processor and outgoing slots carry traffic the other way. Each slot is a small ring of fixed-size message buffers. A producer fills a buffer with a claim, word writes and a ready command, and the consumer reads the oldest message and then frees it.

The host sees a 32-bit, byte-addressed register space with single-cycle writes and combinational reads. Through it the host drives commands, reads slot status, writes incoming messages and reads outgoing ones. A small global area reports the slot counts and a bitmap of outgoing slots that hold unread messages. It also holds an interrupt mask and a coalescing threshold. On the processor side, a plain port pops incoming messages and pushes outgoing ones. The interrupt output tells the host that outgoing traffic is waiting.

Top module: `slot_msg_queue`

## Requirements
- R1: After reset every slot is empty and unclaimed, global registers 4, 8 and 12 read 0, irq is 0, and an empty slot's status reads 0x40000008 with the default geometry.
- R2: Byte address 0x4000 + 0x400*x selects incoming slot x and 0x8000 + 0x400*x selects outgoing slot x. Inside a slot, offset 0 is the command word, offset 4 is the status word and offset 8 + 4*i is message word i. The global registers sit at 0x0, 0x4, 0x8 and 0xC. Any other address, and any slot number at or above the slot count, reads 0 and ignores writes.
- R3: A claim (command bit 24) followed by word writes and a ready command (bit 26, word count in bits 7:0) commits one message. The consumer then sees the same words and that count.
- R4: A ready command without a preceding claim is ignored. A claim on a full slot is ignored. Data words written while the slot is not claimed are not stored.
- R5: Status bit 0 is 1 when the slot holds ENTRIES messages. Bits 23:16 hold the head message's count, or 0 when the slot is empty. Bits 7:2 hold log2(ENTRIES) and bits 31:28 hold log2(WORDS). All other bits read 0.
- R6: Messages leave a slot in the order they were committed, and the ring wraps without loss.
- R7: Discard (bit 27) on an outgoing slot frees its head message, and has no effect when the slot is empty. Purge (bit 25) empties any slot, drops a pending claim and clears the slot's pending bit.
- R8: Global register 0 reads the incoming slot count in bits 7:0 and the outgoing slot count in bits 15:8, and ignores writes. In global register 4, bit x is set while outgoing slot x holds a message. Registers 8 (mask) and 12 (coalesce) are read/write.
- R9: irq is 1 when (pending bitmap AND mask) is non-zero and either the coalesce value is 0 or the number of messages held in masked outgoing slots is at least the coalesce value.
- R10: A command word acts once, with priority purge, then ready, then claim, then discard. A host claim or ready on an outgoing slot is ignored, and so is a host discard on an incoming slot.
- R11: A ready count above WORDS is stored and reported as WORDS.
- R12: The processor commits outgoing messages with claim, word writes and ready, and pops incoming messages with a one-cycle pop. cpu_in_avail and cpu_out_full show, for each slot, whether it is non-empty and whether it is full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe, one cycle per write |
| host_addr | input | AW | Host byte address |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, combinational from host_addr |
| cpu_in_sel | input | ISW | Incoming slot chosen by the processor |
| cpu_in_idx | input | log2(WORDS) | Word index of the head message to read |
| cpu_in_pop | input | 1 | Frees the head message of the chosen incoming slot |
| cpu_in_data | output | 32 | Head message word at cpu_in_idx |
| cpu_in_count | output | 8 | Head message word count, 0 when empty |
| cpu_in_avail | output | N_IN | Per incoming slot: holds a message |
| cpu_out_sel | input | OSW | Outgoing slot chosen by the processor |
| cpu_out_claim | input | 1 | Claims a buffer in the chosen outgoing slot |
| cpu_out_wr | input | 1 | Writes one word of the claimed buffer |
| cpu_out_idx | input | log2(WORDS) | Word index for cpu_out_wr |
| cpu_out_wdata | input | 32 | Word data for cpu_out_wr |
| cpu_out_ready | input | 1 | Commits the claimed buffer |
| cpu_out_count | input | 8 | Word count for cpu_out_ready |
| cpu_out_full | output | N_OUT | Per outgoing slot: full |
| irq | output | 1 | Host interrupt request |

## Verification
A wrong fill count or pointer shows up at the ports in the next cycle. It appears as a wrong full bit or head count in the status word, a wrong bit in the pending bitmap or in cpu_in_avail, or a message read back in the wrong order or with the wrong words. A claim flag that survives a purge or a commit shows up as a later ready that commits a message it should not, which the next status read exposes. Mistakes in the coalescing sum or the mask show up at once on irq, because the bench sweeps every threshold against every fill level.

// File: rtl/mq_pkg.sv
`timescale 1ns/1ps
package mq_pkg;

  typedef enum logic [1:0] {RGN_GLOBAL = 2'd0, RGN_IN = 2'd1, RGN_OUT = 2'd2, RGN_NONE = 2'd3} region_e;
  typedef enum logic [1:0] {OFF_CMD = 2'd0, OFF_STATUS = 2'd1, OFF_DATA = 2'd2, OFF_NONE = 2'd3} offset_e;

  // one action per command word: purge > ready > claim > discard
  typedef struct packed {
    logic purge;
    logic ready;
    logic claim;
    logic discard;
  } cmd_t;

  function automatic cmd_t decode_cmd(input logic [31:0] w);
    cmd_t c;
    c.purge   = w[25];
    c.ready   = w[26] & ~w[25];
    c.claim   = w[24] & ~w[25] & ~w[26];
    c.discard = w[27] & ~w[24] & ~w[25] & ~w[26];
    return c;
  endfunction

  function automatic logic [7:0] clamp_count(input logic [7:0] req, input int unsigned limit);
    if (32'(req) > limit) return 8'(limit);
    return req;
  endfunction

  function automatic logic [31:0] pack_status(input logic full, input logic [7:0] cnt,
                                              input logic [5:0] l2e, input logic [3:0] l2w);
    return {l2w, 4'b0, cnt, 8'b0, l2e, 1'b0, full};
  endfunction

  function automatic logic irq_rule(input logic any_pend, input logic [31:0] total,
                                    input logic [31:0] coal);
    return any_pend && ((coal == 32'd0) || (total >= coal));
  endfunction

endpackage

// File: rtl/mq_ring.sv
`timescale 1ns/1ps
module mq_ring import mq_pkg::*; #(
  parameter int ENTRIES = 4,
  parameter int WORDS   = 16,
  localparam int EW = $clog2(ENTRIES),
  localparam int WW = $clog2(WORDS),
  localparam int FW = $clog2(ENTRIES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          p_claim,
  input  logic          p_wr,
  input  logic [WW-1:0] p_widx,
  input  logic [31:0]   p_wdata,
  input  logic          p_ready,
  input  logic [7:0]    p_count,
  input  logic          purge,
  input  logic          c_discard,
  input  logic [WW-1:0] c_widx,
  output logic [31:0]   c_rdata,
  output logic [7:0]    c_count,
  output logic          full,
  output logic [FW-1:0] fill
);

  logic [EW-1:0] wr_ptr, rd_ptr;
  logic [FW-1:0] fill_q;
  logic          claim_q;
  logic [7:0]    cnt_q [ENTRIES];
  logic [31:0]   mem [ENTRIES*WORDS];

  logic pending;
  logic ev_claim, ev_write, ev_commit, ev_drop;

  assign pending   = (fill_q != '0);
  assign full      = (fill_q == FW'(ENTRIES));
  assign fill      = fill_q;
  assign ev_claim  = p_claim && !purge && !claim_q && !full;
  assign ev_write  = p_wr && claim_q && !purge;
  assign ev_commit = p_ready && claim_q && !purge;
  assign ev_drop   = c_discard && pending && !purge;

  always_ff @(posedge clk) begin
    if (!rst_n || purge) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      fill_q  <= '0;
      claim_q <= 1'b0;
      if (!rst_n) begin
        for (int j = 0; j < ENTRIES; j++) cnt_q[j] <= '0;
      end
    end else begin
      if (ev_claim) claim_q <= 1'b1;
      if (ev_commit) begin
        cnt_q[wr_ptr] <= clamp_count(p_count, WORDS);
        wr_ptr        <= wr_ptr + EW'(1);
        claim_q       <= 1'b0;
      end
      if (ev_drop) rd_ptr <= rd_ptr + EW'(1);
      fill_q <= fill_q + FW'(ev_commit) - FW'(ev_drop);
    end
  end

  always_ff @(posedge clk) begin
    if (ev_write) mem[{wr_ptr, p_widx}] <= p_wdata;
  end

  assign c_rdata = mem[{rd_ptr, c_widx}];
  assign c_count = pending ? cnt_q[rd_ptr] : 8'd0;

  p_fill_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fill_q <= FW'(ENTRIES));
  p_claim_full_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !claim_q && p_claim && !purge) |=> !claim_q);
  p_ready_unclaimed_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!claim_q && p_ready && !purge && !c_discard) |=> $stable(fill_q));
  p_purge_empties_r7: assert property (@(posedge clk) disable iff (!rst_n)
    purge |=> (fill_q == '0) && !claim_q);
  p_discard_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!pending && c_discard && !purge && !(p_ready && claim_q)) |=> !pending);
  p_commit_grows_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_commit && !ev_drop) |=> fill_q == $past(fill_q) + FW'(1));

endmodule

// File: rtl/mq_host_dec.sv
`timescale 1ns/1ps
module mq_host_dec import mq_pkg::*; #(
  parameter int AW    = 16,
  parameter int WORDS = 16,
  localparam int WW = $clog2(WORDS)
) (
  input  logic [AW-1:0] addr,
  output region_e       rgn,
  output offset_e       off,
  output logic [3:0]    slot,
  output logic [1:0]    greg,
  output logic [WW-1:0] widx
);

  logic       hi_zero;
  logic [7:0] word;
  logic       unused_lsb;

  if (AW > 16) begin : g_hi
    assign hi_zero = (addr[AW-1:16] == '0);
  end else begin : g_lo
    assign hi_zero = 1'b1;
  end

  assign word       = addr[9:2];
  assign slot       = addr[13:10];
  assign greg       = addr[3:2];
  assign widx       = WW'(word - 8'd2);
  assign unused_lsb = ^addr[1:0];

  always_comb begin
    rgn = RGN_NONE;
    if (hi_zero) begin
      unique case (addr[15:14])
        2'b00:   rgn = (addr[13:4] == '0) ? RGN_GLOBAL : RGN_NONE;
        2'b01:   rgn = RGN_IN;
        2'b10:   rgn = RGN_OUT;
        default: rgn = RGN_NONE;
      endcase
    end
    if (word == 8'd0)                        off = OFF_CMD;
    else if (word == 8'd1)                   off = OFF_STATUS;
    else if (32'(word) - 32'd2 < 32'(WORDS)) off = OFF_DATA;
    else                                     off = OFF_NONE;
  end

endmodule

// File: rtl/mq_irq.sv
`timescale 1ns/1ps
module mq_irq import mq_pkg::*; #(
  parameter int N_OUT = 2,
  parameter int FW    = 3
) (
  input  logic [N_OUT-1:0]    pend,
  input  logic [N_OUT*FW-1:0] fill_flat,
  input  logic [N_OUT-1:0]    mask,
  input  logic [31:0]         coal,
  output logic [31:0]         total,
  output logic                irq
);

  always_comb begin
    total = '0;
    for (int k = 0; k < N_OUT; k++) begin
      if (mask[k]) total = total + 32'(fill_flat[k*FW +: FW]);
    end
  end

  assign irq = irq_rule(|(pend & mask), total, coal);

endmodule

// File: rtl/slot_msg_queue.sv
`timescale 1ns/1ps
module slot_msg_queue import mq_pkg::*; #(
  parameter int N_IN    = 2,
  parameter int N_OUT   = 2,
  parameter int ENTRIES = 4,
  parameter int WORDS   = 16,
  parameter int AW      = 16,
  localparam int WW  = $clog2(WORDS),
  localparam int ISW = (N_IN > 1) ? $clog2(N_IN) : 1,
  localparam int OSW = (N_OUT > 1) ? $clog2(N_OUT) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_wr,
  input  logic [AW-1:0]    host_addr,
  input  logic [31:0]      host_wdata,
  output logic [31:0]      host_rdata,
  input  logic [ISW-1:0]   cpu_in_sel,
  input  logic [WW-1:0]    cpu_in_idx,
  input  logic             cpu_in_pop,
  output logic [31:0]      cpu_in_data,
  output logic [7:0]       cpu_in_count,
  output logic [N_IN-1:0]  cpu_in_avail,
  input  logic [OSW-1:0]   cpu_out_sel,
  input  logic             cpu_out_claim,
  input  logic             cpu_out_wr,
  input  logic [WW-1:0]    cpu_out_idx,
  input  logic [31:0]      cpu_out_wdata,
  input  logic             cpu_out_ready,
  input  logic [7:0]       cpu_out_count,
  output logic [N_OUT-1:0] cpu_out_full,
  output logic             irq
);

  localparam int FW  = $clog2(ENTRIES + 1);
  localparam logic [5:0] L2E = 6'($clog2(ENTRIES));
  localparam logic [3:0] L2W = 4'($clog2(WORDS));

  region_e       rgn;
  offset_e       off;
  logic [3:0]    slot;
  logic [1:0]    greg;
  logic [WW-1:0] h_widx;
  cmd_t          hcmd;

  logic [31:0] mask_q, coal_q;
  logic [31:0] coal_total;

  logic [31:0]   in_rdata  [N_IN];
  logic [7:0]    in_count  [N_IN];
  logic [FW-1:0] in_fill   [N_IN];
  logic [N_IN-1:0] in_full;

  logic [31:0]   out_rdata [N_OUT];
  logic [7:0]    out_count [N_OUT];
  logic [FW-1:0] out_fill  [N_OUT];
  logic [N_OUT-1:0] out_full, out_pend;
  logic [N_OUT*FW-1:0] out_fill_flat;

  logic in_hit, out_hit, cpu_in_ok;
  logic [ISW-1:0] in_ix;
  logic [OSW-1:0] out_ix;
  logic h_cmd_wr, h_data_wr, g_wr;

  mq_host_dec #(.AW(AW), .WORDS(WORDS)) u_dec (
    .addr(host_addr), .rgn(rgn), .off(off), .slot(slot), .greg(greg), .widx(h_widx)
  );

  assign hcmd      = decode_cmd(host_wdata);
  assign in_hit    = (32'(slot) < N_IN);
  assign out_hit   = (32'(slot) < N_OUT);
  assign in_ix     = ISW'(slot);
  assign out_ix    = OSW'(slot);
  assign h_cmd_wr  = host_wr && (off == OFF_CMD);
  assign h_data_wr = host_wr && (off == OFF_DATA);
  assign g_wr      = host_wr && (rgn == RGN_GLOBAL);

  // incoming: host produces, processor consumes
  for (genvar k = 0; k < N_IN; k++) begin : g_in
    logic hit;
    assign hit = (rgn == RGN_IN) && (slot == 4'(k));
    mq_ring #(.ENTRIES(ENTRIES), .WORDS(WORDS)) u_ring (
      .clk(clk), .rst_n(rst_n),
      .p_claim(hit && h_cmd_wr && hcmd.claim),
      .p_wr(hit && h_data_wr), .p_widx(h_widx), .p_wdata(host_wdata),
      .p_ready(hit && h_cmd_wr && hcmd.ready), .p_count(host_wdata[7:0]),
      .purge(hit && h_cmd_wr && hcmd.purge),
      .c_discard(cpu_in_pop && (cpu_in_sel == ISW'(k))),
      .c_widx(cpu_in_idx), .c_rdata(in_rdata[k]), .c_count(in_count[k]),
      .full(in_full[k]), .fill(in_fill[k])
    );
    assign cpu_in_avail[k] = (in_fill[k] != '0);
  end

  // outgoing: processor produces, host consumes
  for (genvar k = 0; k < N_OUT; k++) begin : g_out
    logic hit, psel;
    assign hit  = (rgn == RGN_OUT) && (slot == 4'(k));
    assign psel = (cpu_out_sel == OSW'(k));
    mq_ring #(.ENTRIES(ENTRIES), .WORDS(WORDS)) u_ring (
      .clk(clk), .rst_n(rst_n),
      .p_claim(psel && cpu_out_claim),
      .p_wr(psel && cpu_out_wr), .p_widx(cpu_out_idx), .p_wdata(cpu_out_wdata),
      .p_ready(psel && cpu_out_ready), .p_count(cpu_out_count),
      .purge(hit && h_cmd_wr && hcmd.purge),
      .c_discard(hit && h_cmd_wr && hcmd.discard),
      .c_widx(h_widx), .c_rdata(out_rdata[k]), .c_count(out_count[k]),
      .full(out_full[k]), .fill(out_fill[k])
    );
    assign out_pend[k] = (out_fill[k] != '0);
    assign out_fill_flat[k*FW +: FW] = out_fill[k];

    p_empty_no_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (out_fill[k] == '0) |-> (out_count[k] == 8'd0));
    p_count_clamp_r11: assert property (@(posedge clk) disable iff (!rst_n)
      out_count[k] <= 8'(WORDS));
  end

  assign cpu_out_full = out_full;

  assign cpu_in_ok    = (32'(cpu_in_sel) < N_IN);
  assign cpu_in_data  = cpu_in_ok ? in_rdata[cpu_in_sel] : 32'd0;
  assign cpu_in_count = cpu_in_ok ? in_count[cpu_in_sel] : 8'd0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '0;
      coal_q <= '0;
    end else if (g_wr) begin
      if (greg == 2'd2) mask_q <= host_wdata;
      if (greg == 2'd3) coal_q <= host_wdata;
    end
  end

  mq_irq #(.N_OUT(N_OUT), .FW(FW)) u_irq (
    .pend(out_pend), .fill_flat(out_fill_flat), .mask(mask_q[N_OUT-1:0]),
    .coal(coal_q), .total(coal_total), .irq(irq)
  );

  always_comb begin
    host_rdata = 32'd0;
    unique case (rgn)
      RGN_GLOBAL: begin
        unique case (greg)
          2'd0:    host_rdata = {16'd0, 8'(N_OUT), 8'(N_IN)};
          2'd1:    host_rdata = {16'd0, 16'(out_pend)};
          2'd2:    host_rdata = mask_q;
          default: host_rdata = coal_q;
        endcase
      end
      RGN_IN: begin
        if (in_hit && off == OFF_STATUS)
          host_rdata = pack_status(in_full[in_ix], in_count[in_ix], L2E, L2W);
      end
      RGN_OUT: begin
        if (out_hit && off == OFF_STATUS)
          host_rdata = pack_status(out_full[out_ix], out_count[out_ix], L2E, L2W);
        else if (out_hit && off == OFF_DATA)
          host_rdata = out_rdata[out_ix];
      end
      default: host_rdata = 32'd0;
    endcase
  end

  p_irq_masked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((out_pend & mask_q[N_OUT-1:0]) != '0));
  p_irq_coal_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && coal_q != 32'd0) |-> (coal_total >= coal_q));
  p_mask_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (g_wr && greg == 2'd2) |=> (mask_q == $past(host_wdata)));

endmodule

// File: tb/test_slot_msg_queue.sv
`timescale 1ns/1ps
module test_slot_msg_queue;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr = 1'b0;
  logic [15:0] host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        cpu_in_sel = 1'b0;
  logic [3:0]  cpu_in_idx = '0;
  logic        cpu_in_pop = 1'b0;
  logic [31:0] cpu_in_data;
  logic [7:0]  cpu_in_count;
  logic [1:0]  cpu_in_avail;
  logic        cpu_out_sel = 1'b0;
  logic        cpu_out_claim = 1'b0;
  logic        cpu_out_wr = 1'b0;
  logic [3:0]  cpu_out_idx = '0;
  logic [31:0] cpu_out_wdata = '0;
  logic        cpu_out_ready = 1'b0;
  logic [7:0]  cpu_out_count = '0;
  logic [1:0]  cpu_out_full;
  logic        irq;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  slot_msg_queue i_slot_msg_queue (.*);

  localparam logic [31:0] CLAIM = 32'h0100_0000, PURGE = 32'h0200_0000,
                          READY = 32'h0400_0000, DISCARD = 32'h0800_0000;

  function automatic logic [15:0] in_a(int s, int o);
    return 16'(32'h4000 + s * 32'h400 + o);
  endfunction
  function automatic logic [15:0] out_a(int s, int o);
    return 16'(32'h8000 + s * 32'h400 + o);
  endfunction
  function automatic logic [31:0] dv(int s, int e, int i);
    return 32'hC0DE_0000 ^ 32'(s << 12) ^ 32'(e << 6) ^ 32'(i);
  endfunction
  // status: log2 words 4 at 31:28, count at 23:16, log2 entries 2 at 7:2, full at 0
  function automatic logic [31:0] st(int full, int cnt);
    return (32'd4 << 28) | 32'(cnt << 16) | (32'd2 << 2) | 32'(full);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic hw(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic hr(input logic [15:0] a, output logic [31:0] d);
    host_addr = a;
    #1;
    d = host_rdata;
  endtask

  task automatic host_push(input int s, input int e, input int cnt);
    hw(in_a(s, 0), CLAIM);
    for (int i = 0; i < cnt; i++) hw(in_a(s, 8 + 4 * i), dv(s, e, i));
    hw(in_a(s, 0), READY | 32'(cnt));
  endtask

  task automatic cpu_push(input int s, input int e, input int cnt);
    @(negedge clk);
    cpu_out_sel = 1'(s); cpu_out_claim = 1'b1;
    @(negedge clk);
    cpu_out_claim = 1'b0;
    for (int i = 0; i < cnt; i++) begin
      cpu_out_wr = 1'b1; cpu_out_idx = 4'(i); cpu_out_wdata = dv(8 + s, e, i);
      @(negedge clk);
    end
    cpu_out_wr = 1'b0; cpu_out_ready = 1'b1; cpu_out_count = 8'(cnt);
    @(negedge clk);
    cpu_out_ready = 1'b0;
  endtask

  task automatic cpu_pop(input int s);
    @(negedge clk);
    cpu_in_sel = 1'(s); cpu_in_pop = 1'b1;
    @(negedge clk);
    cpu_in_pop = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog: got %h expected %h", 32'd0, 32'd1);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state, R8 global registers, R2 unmapped reads
    hr(16'h0000, r); chk("R8 slot counts", r, 32'h0000_0202);
    hr(16'h0004, r); chk("R1 pending map", r, 32'd0);
    hr(16'h0008, r); chk("R1 mask", r, 32'd0);
    hr(16'h000C, r); chk("R1 coalesce", r, 32'd0);
    chk("R1 irq", 32'(irq), 32'd0);
    chk("R1 avail", 32'(cpu_in_avail), 32'd0);
    for (int s = 0; s < 2; s++) begin
      hr(in_a(s, 4), r);  chk("R1 in status", r, st(0, 0));
      hr(out_a(s, 4), r); chk("R1 out status", r, st(0, 0));
    end
    hr(in_a(3, 4), r); chk("R2 absent slot", r, 32'd0);
    hr(16'hC004, r);   chk("R2 unmapped", r, 32'd0);
    hw(16'h0000, 32'hFFFF_FFFF);
    hr(16'h0000, r); chk("R8 reg0 read-only", r, 32'h0000_0202);
    hw(16'h0008, 32'h1234_5678);
    hr(16'h0008, r); chk("R8 mask rw", r, 32'h1234_5678);
    hw(16'h0008, 32'd0);

    // incoming slots: host produces, processor consumes
    for (int s = 0; s < 2; s++) begin
      for (int e = 0; e < 4; e++) begin
        host_push(s, e, e * 5 + 1);
        hr(in_a(s, 4), r);
        chk("R5 in status while filling", r, st(e == 3 ? 1 : 0, 1));
        chk("R12 avail", 32'(cpu_in_avail[s]), 32'd1);
      end
      hw(in_a(s, 0), CLAIM);
      hw(in_a(s, 0), READY | 32'd2);
      hr(in_a(s, 4), r); chk("R4 claim on full", r, st(1, 1));
      cpu_in_sel = 1'(s);
      for (int e = 0; e < 4; e++) begin
        @(negedge clk);
        chk("R6 in count order", 32'(cpu_in_count), 32'(e * 5 + 1));
        for (int i = 0; i < e * 5 + 1; i++) begin
          cpu_in_idx = 4'(i); #1;
          chk("R3 in words", cpu_in_data, dv(s, e, i));
        end
        cpu_pop(s);
      end
      chk("R4 rejected message absent", 32'(cpu_in_avail[s]), 32'd0);
      hw(in_a(s, 0), READY | 32'd5);
      chk("R4 ready without claim", 32'(cpu_in_avail[s]), 32'd0);
      hw(in_a(s, 8), 32'hDEAD_0000);
      hw(in_a(s, 0), CLAIM);
      hw(in_a(s, 0), READY | 32'd1);
      cpu_in_sel = 1'(s); cpu_in_idx = 4'd0; #1;
      chk("R4 unclaimed write dropped", cpu_in_data, dv(s, 0, 0));
      chk("R6 wrapped count", 32'(cpu_in_count), 32'd1);
      cpu_pop(s);
      hw(in_a(s, 0), CLAIM);
      hw(in_a(s, 0), READY | 32'hFF);
      hr(in_a(s, 4), r); chk("R11 count clamp", r, st(0, 16));
      hw(in_a(s, 0), DISCARD);
      chk("R10 host discard on incoming", 32'(cpu_in_avail[s]), 32'd1);
      hw(in_a(s, 0), CLAIM);
      hw(in_a(s, 0), PURGE | READY | 32'd3);
      chk("R7 purge empties", 32'(cpu_in_avail[s]), 32'd0);
      hw(in_a(s, 0), READY | 32'd3);
      chk("R7 purge drops claim", 32'(cpu_in_avail[s]), 32'd0);
      hw(in_a(s, 0), CLAIM | READY | 32'd3);
      hw(in_a(s, 0), READY | 32'd3);
      chk("R10 ready beats claim", 32'(cpu_in_avail[s]), 32'd0);
      hr(in_a(s, 4), r); chk("R5 empty status", r, st(0, 0));
    end

    // outgoing slots: processor produces, host consumes; irq sweep
    for (int s = 0; s < 2; s++) begin
      hw(16'h0008, 32'(1 << s));
      for (int n = 0; n <= 4; n++) begin
        if (n > 0) cpu_push(s, n - 1, 16 - 3 * (n - 1));
        for (int c = 0; c <= 5; c++) begin
          hw(16'h000C, 32'(c));
          chk("R9 irq sweep", 32'(irq), 32'((n > 0) && (c == 0 || n >= c)));
        end
        hr(16'h0004, r); chk("R8 pending bit", r, (n > 0) ? 32'(1 << s) : 32'd0);
        chk("R12 out full", 32'(cpu_out_full[s]), 32'(n == 4));
      end
      hw(16'h0008, 32'd0);
      chk("R9 masked off", 32'(irq), 32'd0);
      hw(out_a(s, 0), CLAIM);
      hw(out_a(s, 0), READY | 32'd2);
      for (int e = 0; e < 4; e++) begin
        hr(out_a(s, 4), r); chk("R5 out status", r, st(e == 0 ? 1 : 0, 16 - 3 * e));
        for (int i = 0; i < 16 - 3 * e; i++) begin
          hr(out_a(s, 8 + 4 * i), r); chk("R6 out words", r, dv(8 + s, e, i));
        end
        hw(out_a(s, 0), DISCARD);
      end
      hr(16'h0004, r); chk("R7 pending cleared", r, 32'd0);
      hw(out_a(s, 0), DISCARD);
      cpu_push(s, 7, 2);
      hr(out_a(s, 4), r); chk("R7 discard on empty", r, st(0, 2));
      hw(out_a(s, 0), DISCARD);
      hr(16'h0004, r); chk("R7 no underflow", r, 32'd0);
      cpu_push(s, 8, 1);
      cpu_push(s, 9, 1);
      hw(out_a(s, 0), PURGE);
      hr(16'h0004, r); chk("R7 out purge", r, 32'd0);
    end

    // coalescing across two masked slots
    cpu_push(0, 10, 1);
    cpu_push(1, 11, 1);
    hw(16'h000C, 32'd2);
    hw(16'h0008, 32'd3);
    chk("R9 sum of masked slots", 32'(irq), 32'd1);
    hw(16'h0008, 32'd1);
    chk("R9 one masked slot below threshold", 32'(irq), 32'd0);
    hr(16'h0004, r); chk("R8 both pending", r, 32'd3);
    hw(out_a(0, 0), PURGE);
    hw(out_a(1, 0), PURGE);
    hr(16'h0004, r); chk("R7 both purged", r, 32'd0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule